// File: doc/BRIEF.md
# Prescaled 8-bit Event Timer

This block is an 8-bit up-counter with its own small register bus. A 3-bit clock-select field picks what advances the counter:
- nothing (stopped);
- every system clock;
- one of four rates taken from a shared 10-bit free-running prescaler;
- edges of an external pin, on a chosen polarity.

The pin is first brought into the system clock domain by a two-flop synchroniser. An edge-detect register follows it, so a pin edge reaches the counter a fixed number of cycles late.

When the counter wraps from 255 to 0 it sets a sticky overflow flag. Software clears the flag by writing one to it. The interrupt request output is the flag gated by a mask bit.

A write-only command bit in the control register restarts the prescaler, so that a divided rate starts from a known phase. The counter register can be loaded directly. A load takes precedence over any increment in the same cycle.

Top module: `byte_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq` is low.
- R2: The control register sits at address 0. Bits 2:0 hold the clock select and read back as written. Bits 7:3 always read as zero.
- R3: Writing the control register with bit 3 set restarts the prescaler. With a divide-by-N select, the next increment comes N cycles after that write's clock edge. A control write with bit 3 clear leaves the prescaler phase unchanged.
- R4: With select 000 the counter holds its value.
- R5: With select 001 the counter advances by one on every clock edge. The first step comes one edge after the select is written.
- R6: Selects 010, 011, 100 and 101 advance the counter once every 8, 64, 256 and 1024 cycles. After a prescaler restart, the first step lands exactly N edges later.
- R7: Select 111 counts rising pin edges and 110 counts falling pin edges. Suppose edge A is the first clock edge that samples the new pin level. The counter then steps at edge A+2. Edges of the other polarity are ignored.
- R8: The overflow flag is bit 0 at address 2. It is set when the counter steps from 255 to 0. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R9: The mask is bit 0 at address 3. `irq` is high exactly when both the flag and the mask are set.
- R10: The counter sits at address 1. A write to it loads the value at that clock edge and cancels an increment in the same cycle, including one that would wrap and set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 flag, 3 mask |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_pin | input | 1 | External count input, asynchronous |
| irq | output | 1 | Interrupt request: flag AND mask |

## Verification
A wrong prescaler phase or tap shows on the counter read-back as a step one or more cycles off the N-cycle grid after a restart. It is visible within one divided period. A broken synchroniser depth or a swapped edge polarity moves or removes the step that should follow a pin transition. That shows within three cycles of the edge. A flag that fails to set, fails to stick or fails to clear shows directly at `irq` and at the flag read on the next cycle. So does a load that does not take priority over an increment.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Data width of the register bus and of the counter
    localparam int DW = 8;

    // Register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_FLAG = 2'd2;
    localparam logic [1:0] A_MASK = 2'd3;

    // Write-only prescaler restart command in the control register
    localparam int CTRL_PRST_BIT = 3;

    // Number of divided rates taken from the prescaler
    localparam int N_DIV = 4;

    // Clock-select codes
    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clksel_e;

    // Prescaler bit count whose all-ones state marks a divided tick:
    // index 0 -> /8, 1 -> /64, 2 -> /256, 3 -> /1024
    function automatic int div_tap(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    typedef struct packed {
        clksel_e       cs;
        logic [DW-1:0] cnt;
        logic          ovf;
        logic          msk;
    } tmr_state_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int W = 10   // must cover the widest tap, div_tap(N_DIV-1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [N_DIV-1:0] ticks
);

    logic [W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = clr ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // A tap fires while its low bits are all ones: once per 2**tap cycles
    for (genvar i = 0; i < N_DIV; i++) begin : g_tap
        localparam int TB = div_tap(i);
        assign ticks[i] = &pre_q[TB-1:0];
    end

endmodule

// File: rtl/tmr_edgesync.sv
module tmr_edgesync #(
    parameter int STAGES = 2   // at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;
    logic  synced;

    assign synced = s_q.sh[STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin};
        s_d.last = synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = synced & ~s_q.last;
    assign fall = ~synced & s_q.last;

endmodule

// File: rtl/byte_timer.sv
module byte_timer
    import tmr_pkg::*;
#(
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_pin,
    output logic          irq
);

    localparam int CS_W = $bits(clksel_e);

    tmr_state_t       st_d, st_q;
    logic             wr_ctrl, wr_cnt, wr_flag, wr_mask;
    logic             prst;
    logic [N_DIV-1:0] div_ticks;
    logic             ext_rise, ext_fall;
    logic             tick;
    logic             wrap;

    // Write decode
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_cnt  = bus_wr && (bus_addr == A_CNT);
        wr_flag = bus_wr && (bus_addr == A_FLAG);
        wr_mask = bus_wr && (bus_addr == A_MASK);
    end

    // The restart command is a one-cycle pulse; it is never stored
    assign prst = wr_ctrl & bus_wdata[CTRL_PRST_BIT];

    tmr_prescale #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (prst),
        .ticks (div_ticks)
    );

    tmr_edgesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Count-enable selection
    always_comb begin
        case (st_q.cs)
            CS_DIV1:     tick = 1'b1;
            CS_DIV8:     tick = div_ticks[0];
            CS_DIV64:    tick = div_ticks[1];
            CS_DIV256:   tick = div_ticks[2];
            CS_DIV1024:  tick = div_ticks[3];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = 1'b0;
        endcase
    end

    assign wrap = tick && !wr_cnt && (st_q.cnt == {DW{1'b1}});

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.cs  = clksel_e'(bus_wdata[CS_W-1:0]);
        if (wr_mask) st_d.msk = bus_wdata[0];
        if (wr_cnt)    st_d.cnt = bus_wdata;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
        // Setting on a wrap wins over a clear written in the same cycle
        if (wr_flag && bus_wdata[0]) st_d.ovf = 1'b0;
        if (wrap)                    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs: CS_STOP, cnt: '0, ovf: 1'b0, msk: 1'b0};
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(DW-CS_W){1'b0}}, st_q.cs};
            A_CNT:   bus_rdata = st_q.cnt;
            A_FLAG:  bus_rdata = {{(DW-1){1'b0}}, st_q.ovf};
            default: bus_rdata = {{(DW-1){1'b0}}, st_q.msk};
        endcase
    end

    assign irq = st_q.ovf & st_q.msk;

endmodule

// File: rtl/byte_timer_chk.sv
module byte_timer_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic [2:0]    cs,
    input logic [DW-1:0] cnt,
    input logic          ovf,
    input logic          msk,
    input logic          tick
);

    logic cnt_wr, flag_clr;
    assign cnt_wr   = bus_wr && (bus_addr == A_CNT);
    assign flag_clr = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[DW-1:3] == '0)); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == 3'd0 && !cnt_wr) |=> (cnt == $past(cnt))); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && cnt != $past(cnt)) |-> (cnt == DW'($past(cnt) + 1'b1))); // R6

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == {DW{1'b1}} && !cnt_wr) |=> ovf); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flag_clr) |=> ovf); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(bus_wdata) && ovf == $past(ovf))); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !msk |-> !irq); // R9

endmodule

bind byte_timer byte_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cs        (st_q.cs),
    .cnt       (st_q.cnt),
    .ovf       (st_q.ovf),
    .msk       (st_q.msk),
    .tick      (tick)
);

// File: tb/byte_timer_tb.sv
`timescale 1ns/1ps
module byte_timer_tb;
    import tmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    byte_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_pin   (ext_pin),
        .irq       (irq)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_reg(input string what, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        chk(what, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl after reset", A_CTRL, 8'h00);
        expect_reg("R1 count after reset", A_CNT, 8'h00);
        expect_reg("R1 flag after reset", A_FLAG, 8'h00);
        expect_reg("R1 mask after reset", A_MASK, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_ctrl_readback();
        wr(A_CTRL, 8'hFD);
        expect_reg("R2 reserved and restart bits read zero", A_CTRL, 8'h05);
        wr(A_CTRL, 8'h03);
        expect_reg("R2 select reads back", A_CTRL, 8'h03);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_stop();
        wr(A_CNT, 8'h33);
        idle(20);
        expect_reg("R4 stopped counter holds", A_CNT, 8'h33);
    endtask

    // Checks the first two steps after a prescaler restart at edge E0
    task automatic t_rate(input logic [2:0] code, input int n, input string tag);
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h00);
        wr(A_CTRL, {5'b00001, code});
        idle(n - 1);
        expect_reg({tag, " no step before N edges"}, A_CNT, 8'h00);
        idle(1);
        expect_reg({tag, " first step at N edges"}, A_CNT, 8'h01);
        idle(n);
        expect_reg({tag, " second step at 2N edges"}, A_CNT, 8'h02);
    endtask

    task automatic t_prescaler_restart();
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h0A);          // restart at E0, /8
        idle(3);
        wr(A_CTRL, 8'h02);          // E4: bit 3 clear, phase kept
        idle(3);
        expect_reg("R3 plain write keeps phase (E7)", A_CNT, 8'h00);
        idle(1);
        expect_reg("R3 plain write keeps phase (E8)", A_CNT, 8'h01);
        idle(3);
        wr(A_CTRL, 8'h0A);          // E12: restart
        idle(4);
        expect_reg("R3 restart delays step (E16)", A_CNT, 8'h01);
        idle(4);
        expect_reg("R3 step N edges after restart (E20)", A_CNT, 8'h02);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_ext();
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h07);
        idle(3);
        ext_pin = 1'b1;
        idle(2);
        expect_reg("R7 rising edge not yet counted at A+1", A_CNT, 8'h00);
        idle(1);
        expect_reg("R7 rising edge counted at A+2", A_CNT, 8'h01);
        ext_pin = 1'b0;
        idle(5);
        expect_reg("R7 falling edge ignored in rising mode", A_CNT, 8'h01);
        wr(A_CTRL, 8'h06);
        ext_pin = 1'b1;
        idle(5);
        expect_reg("R7 rising edge ignored in falling mode", A_CNT, 8'h01);
        ext_pin = 1'b0;
        idle(2);
        expect_reg("R7 falling edge not yet counted at A+1", A_CNT, 8'h01);
        idle(1);
        expect_reg("R7 falling edge counted at A+2", A_CNT, 8'h02);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_wrap_irq();
        wr(A_CTRL, 8'h00);
        wr(A_FLAG, 8'h01);
        wr(A_MASK, 8'h00);
        wr(A_CNT, 8'hFE);
        wr(A_CTRL, 8'h01);
        idle(1);
        expect_reg("R8 no flag at 255", A_FLAG, 8'h00);
        idle(1);
        expect_reg("R8 count wrapped to 0", A_CNT, 8'h00);
        expect_reg("R8 flag set on wrap", A_FLAG, 8'h01);
        chk("R9 irq low while masked", {7'd0, irq}, 8'h00);
        wr(A_CTRL, 8'h00);
        wr(A_FLAG, 8'h00);
        expect_reg("R8 writing zero keeps flag", A_FLAG, 8'h01);
        wr(A_MASK, 8'h01);
        chk("R9 irq high with flag and mask", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'h01);
        expect_reg("R8 writing one clears flag", A_FLAG, 8'h00);
        chk("R9 irq drops with flag", {7'd0, irq}, 8'h00);
        wr(A_MASK, 8'h00);
    endtask

    task automatic t_load();
        wr(A_CTRL, 8'h01);
        wr(A_CNT, 8'h40);
        expect_reg("R10 load replaces increment", A_CNT, 8'h40);
        idle(1);
        expect_reg("R10 counting resumes after load", A_CNT, 8'h41);
        wr(A_FLAG, 8'h01);
        wr(A_CNT, 8'hFF);
        wr(A_CNT, 8'h10);           // lands while count is 255 and ticking
        expect_reg("R10 load at 255 wins over wrap", A_CNT, 8'h10);
        expect_reg("R10 suppressed wrap sets no flag", A_FLAG, 8'h00);
        wr(A_CTRL, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ctrl_readback();
        t_stop();
        t_rate(3'd1, 1, "R5 clock/1");
        t_rate(3'd2, 8, "R6 clock/8");
        t_rate(3'd3, 64, "R6 clock/64");
        t_rate(3'd4, 256, "R6 clock/256");
        t_rate(3'd5, 1024, "R6 clock/1024");
        t_prescaler_restart();
        t_ext();
        t_wrap_irq();
        t_load();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule